// File: doc/BRIEF.md
# Configuration read retry engine

This block turns configuration read requests from a host-side access port into 32-bit reads on a downstream configuration data path. A request names a bus, a device, a function, a register offset and an access size. The block also hides the retry status that a target returns while it is not yet ready.

A downstream response counts as a retry when its data word equals 0xFFFF0001 or its status code equals 2. For such a response the block waits one microsecond and issues the same read again, up to a fixed budget of reissues. If the budget runs out, the result becomes all ones. Reads to bus 0 reach the root's own space over a direct path: they are issued once and returned exactly as received. For one-byte and two-byte accesses, the block picks the addressed lane out of the word.

Requests use a valid/ready handshake. `req_ready` is high only while the block is idle, so a request waits at the input until the previous one has completed. The downstream read request also uses valid/ready: the block holds the read until the path accepts it. Downstream responses and the final result carry no back-pressure. A response is taken only while the block waits for one. The result appears with a one-cycle `done` pulse and must be captured in that cycle.

Top module: `cfgrd_retry_engine`

## Requirements
- R1: `req_ready` is high exactly while no request is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high, and `req_ready` is low from the next cycle until the result has been delivered.
- R2: A request is unmapped when it targets bus 0 with a device number other than 0, or a bus number above `BUS_LAST`. An unmapped request issues no downstream read. `done` pulses in the cycle after acceptance, with `rsp_err` = 1 and `rsp_data` = 0xFFFFFFFF.
- R3: A mapped request issues a read with `rd_addr` = {bus[7:0], dev[4:0], fn[2:0], off[11:2]} and `rd_direct` = 1 exactly when bus is 0. The read is held with a stable address until `rd_req_ready` is high.
- R4: On a bus other than 0, a response whose data is 0xFFFF0001 or whose `rd_rsp_sts` is 2 is a retry. The same read is raised again `CLK_MHZ`+1 cycles after the response cycle, which leaves a wait of `CLK_MHZ` cycles (one microsecond).
- R5: At most `RETRY_LIMIT` reissues are made, so at most `RETRY_LIMIT`+1 reads in total. If the last response is still a retry, the result word is 0xFFFFFFFF.
- R6: A bus-0 request issues exactly one read and returns its data unchanged, even if that data or its status marks a retry.
- R7: For size 1 the result is (word >> 8*off[1:0]) & 0xFF. For size 2 it is (word >> 8*off[1:0]) & 0xFFFF. Lane extraction is also applied to the all-ones timeout word.
- R8: For a size of 4, or any size other than 1 and 2, the result is the full 32-bit word.
- R9: For a mapped request, `done` is high for one cycle, in the cycle after the final response, with `rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| rd_req_valid | output | 1 | Downstream read request |
| rd_req_ready | input | 1 | Downstream path takes the read |
| rd_addr | output | 26 | {bus, dev, fn, word offset} of the read |
| rd_direct | output | 1 | Read goes to the root's own space (bus 0) |
| rd_rsp_valid | input | 1 | Downstream response present |
| rd_rsp_sts | input | 3 | Response status code, 2 = retry |
| rd_rsp_data | input | 32 | Response data word |
| done | output | 1 | One-cycle result strobe |
| rsp_err | output | 1 | Request was unmapped |
| rsp_data | output | 32 | Result, valid while done is high |

## Verification
For a mapped read, `done` is due exactly one cycle after the response that ends the request. For an unmapped request it is due one cycle after the handshake. A retry must be followed by the reissued read `CLK_MHZ`+1 cycles after the retry response. The bench runs with a small clock ratio and a small budget, and counts cycles at each rising edge. It samples every output at the falling edge, compares each cycle distance with these figures, and checks the number of reads the downstream model saw for each request.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int OFF_W  = 12;
  localparam int WORD_W = 32;
  localparam int ADDR_W = BUS_W + DEV_W + FN_W + OFF_W - 2;

  localparam logic [WORD_W-1:0] RETRY_WORD = 32'hFFFF_0001;
  localparam logic [2:0]        STS_RETRY  = 3'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DELAY,
    ST_DONE
  } state_t;
endpackage

// File: rtl/cfgrd_delay.sv
module cfgrd_delay #(
  parameter int CLK_MHZ = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expire
);
  localparam int CW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;

  logic [CW-1:0] cnt;

  assign expire = en && (cnt == CW'(CLK_MHZ - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!en || expire)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R4
  delay_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $past(en));
endmodule

// File: rtl/cfgrd_lane.sv
module cfgrd_lane #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        lane,
  input  logic [2:0]        size,
  output logic [WORD_W-1:0] data
);
  logic [WORD_W-1:0] shifted;

  assign shifted = word >> {lane, 3'b000};

  always_comb begin
    case (size)
      3'd1:    data = {{(WORD_W-8){1'b0}},  shifted[7:0]};
      3'd2:    data = {{(WORD_W-16){1'b0}}, shifted[15:0]};
      default: data = word;
    endcase
  end
endmodule

// File: rtl/cfgrd_retry_engine.sv
module cfgrd_retry_engine
  import cfgrd_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int RETRY_LIMIT = 500000,
  parameter int BUS_LAST    = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [2:0]        req_size,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_direct,
  input  logic              rd_rsp_valid,
  input  logic [2:0]        rd_rsp_sts,
  input  logic [WORD_W-1:0] rd_rsp_data,
  output logic              done,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_data
);
  localparam int TRY_W = $clog2(RETRY_LIMIT + 1);

  state_t            state;
  logic [BUS_W-1:0]  bus_q;
  logic [DEV_W-1:0]  dev_q;
  logic [FN_W-1:0]   fn_q;
  logic [OFF_W-1:0]  off_q;
  logic [2:0]        size_q;
  logic              direct_q;
  logic              err_q;
  logic [TRY_W-1:0]  tries;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] lane_data;
  logic              gap_done;
  logic              mapped;
  logic              rsp_retry;

  assign mapped    = !(((req_bus == '0) && (req_dev != '0)) || (int'(req_bus) > BUS_LAST));
  assign rsp_retry = !direct_q && ((rd_rsp_data == RETRY_WORD) || (rd_rsp_sts == STS_RETRY));

  assign req_ready    = (state == ST_IDLE);
  assign rd_req_valid = (state == ST_ISSUE);
  assign rd_addr      = {bus_q, dev_q, fn_q, off_q[OFF_W-1:2]};
  assign rd_direct    = direct_q;
  assign done         = (state == ST_DONE);
  assign rsp_err      = err_q;
  assign rsp_data     = err_q ? '1 : lane_data;

  cfgrd_delay #(.CLK_MHZ(CLK_MHZ)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (state == ST_DELAY),
    .expire (gap_done)
  );

  cfgrd_lane #(.WORD_W(WORD_W)) u_lane (
    .word (word_q),
    .lane (off_q[1:0]),
    .size (size_q),
    .data (lane_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bus_q    <= '0;
      dev_q    <= '0;
      fn_q     <= '0;
      off_q    <= '0;
      size_q   <= '0;
      direct_q <= 1'b0;
      err_q    <= 1'b0;
      tries    <= '0;
      word_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          bus_q    <= req_bus;
          dev_q    <= req_dev;
          fn_q     <= req_fn;
          off_q    <= req_off;
          size_q   <= req_size;
          direct_q <= (req_bus == '0);
          tries    <= '0;
          if (!mapped) begin
            err_q  <= 1'b1;
            word_q <= '1;
            state  <= ST_DONE;
          end else begin
            err_q  <= 1'b0;
            state  <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid) begin
          if (rsp_retry) begin
            if (tries == TRY_W'(RETRY_LIMIT)) begin
              word_q <= '1;
              state  <= ST_DONE;
            end else begin
              tries <= tries + 1'b1;
              state <= ST_DELAY;
            end
          end else begin
            word_q <= rd_rsp_data;
            state  <= ST_DONE;
          end
        end
        ST_DELAY: if (gap_done) state <= ST_ISSUE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_err) |-> (rsp_data == '1));

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  // R5
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tries) <= RETRY_LIMIT);

  // R6
  direct_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && rd_rsp_valid && direct_q) |=> (state == ST_DONE));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/cfgrd_retry_engine_bench.sv
module cfgrd_retry_engine_bench;
  localparam int CLK_MHZ = 3;
  localparam int LIMIT   = 4;
  localparam int BUS_LAST = 15;
  localparam logic [31:0] MARK = 32'hFFFF_0001;
  localparam logic [31:0] JUNK = 32'h1234_5678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_bus = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_fn = '0;
  logic [11:0] req_off = '0;
  logic [2:0] req_size = '0;
  logic rd_req_valid;
  logic rd_req_ready = 1'b0;
  logic [25:0] rd_addr;
  logic rd_direct;
  logic rd_rsp_valid = 1'b0;
  logic [2:0] rd_rsp_sts = '0;
  logic [31:0] rd_rsp_data = '0;
  logic done;
  logic rsp_err;
  logic [31:0] rsp_data;

  always #5 clk = ~clk;

  cfgrd_retry_engine #(.CLK_MHZ(CLK_MHZ), .RETRY_LIMIT(LIMIT), .BUS_LAST(BUS_LAST)) u_cfgrd_retry_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
    .req_size(req_size), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_addr(rd_addr), .rd_direct(rd_direct), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_sts(rd_rsp_sts), .rd_rsp_data(rd_rsp_data), .done(done),
    .rsp_err(rsp_err), .rsp_data(rsp_data));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int done_cnt = 0;
  int last_rsp_cyc = 0;

  int m_retry = 0;
  bit m_sts = 1'b0;
  logic [31:0] m_final = '0;
  int m_reads = 0;
  int m_stall = 0;
  logic [25:0] m_addr = '0;
  logic m_direct = 1'b0;

  logic [31:0] exp_q[$];
  logic exp_err_q[$];
  string tag_q[$];
  logic prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [31:0] f_lane(input logic [31:0] w, input logic [11:0] off, input logic [2:0] size);
    logic [31:0] s;
    s = w >> (8 * off[1:0]);
    case (size)
      3'd1:    return s & 32'hFF;
      3'd2:    return s & 32'hFFFF;
      default: return w;
    endcase
  endfunction

  // downstream model
  initial begin
    bit pend = 1'b0;
    forever begin
      @(negedge clk);
      rd_req_ready = 1'b0;
      rd_rsp_valid = 1'b0;
      if (pend) begin
        pend = 1'b0;
        rd_rsp_valid = 1'b1;
        last_rsp_cyc = cyc;
        if (m_retry > 0) begin
          m_retry--;
          rd_rsp_sts  = m_sts ? 3'd2 : 3'd0;
          rd_rsp_data = m_sts ? JUNK : MARK;
        end else begin
          rd_rsp_sts  = 3'd0;
          rd_rsp_data = m_final;
        end
      end else if (rd_req_valid) begin
        if (m_stall > 0) begin
          m_stall--;
        end else begin
          rd_req_ready = 1'b1;
          // R3 address and path
          check(rd_addr == m_addr, "R3 rd_addr", {6'b0, rd_addr}, {6'b0, m_addr});
          check(rd_direct == m_direct, "R3 rd_direct", {31'b0, rd_direct}, {31'b0, m_direct});
          // R4 reissue distance
          if (m_reads > 0)
            check(cyc - last_rsp_cyc == CLK_MHZ + 1, "R4 reissue gap",
                  32'(cyc - last_rsp_cyc), 32'(CLK_MHZ + 1));
          m_reads++;
          pend = 1'b1;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (done) begin
      // R9 one-cycle pulse
      check(!prev_done, "R9 done pulse width", {31'b0, prev_done}, 32'd0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", rsp_data, 32'd0);
      end else begin
        logic [31:0] e;
        logic ee;
        string t;
        e = exp_q.pop_front();
        ee = exp_err_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, {t, " data"}, rsp_data, e);
        check(rsp_err == ee, {t, " err"}, {31'b0, rsp_err}, {31'b0, ee});
        if (!ee)
          check(cyc == last_rsp_cyc + 1, "R9 done latency", 32'(cyc - last_rsp_cyc), 32'd1);
      end
      done_cnt++;
    end
    prev_done = done;
  end

  task automatic run_req(input logic [7:0] bus, input logic [4:0] dev, input logic [2:0] fn,
                         input logic [11:0] off, input logic [2:0] size, input int nretry,
                         input bit sts, input logic [31:0] fin, input int stall, input string tag);
    bit err;
    logic [31:0] base;
    int exp_reads;
    int start;
    err = ((bus == 0) && (dev != 0)) || (int'(bus) > BUS_LAST);
    if (err) begin
      base = 32'hFFFF_FFFF; exp_reads = 0;
    end else if (bus == 0) begin
      base = (nretry > 0) ? (sts ? JUNK : MARK) : fin; exp_reads = 1;
    end else if (nretry > LIMIT) begin
      base = 32'hFFFF_FFFF; exp_reads = LIMIT + 1;
    end else begin
      base = fin; exp_reads = nretry + 1;
    end
    m_retry = nretry; m_sts = sts; m_final = fin; m_reads = 0; m_stall = stall;
    m_addr = {bus, dev, fn, off[11:2]}; m_direct = (bus == 0);
    exp_q.push_back(err ? 32'hFFFF_FFFF : f_lane(base, off, size));
    exp_err_q.push_back(err);
    tag_q.push_back(tag);
    start = done_cnt;
    @(negedge clk);
    req_bus = bus; req_dev = dev; req_fn = fn; req_off = off; req_size = size;
    req_valid = 1'b1;
    check(req_ready, "R1 ready when idle", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (err) check(done, "R2 error done next cycle", {31'b0, done}, 32'd1);
    else     check(!req_ready, "R1 ready low while busy", {31'b0, req_ready}, 32'd0);
    while (done_cnt == start) @(negedge clk);
    @(negedge clk);
    check(m_reads == exp_reads, {tag, " read count"}, 32'(m_reads), 32'(exp_reads));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !done && !rd_req_valid, "R1 reset state",
          {29'b0, req_ready, done, rd_req_valid}, 32'b100);
    run_req(8'd1, 5'd2, 3'd3, 12'h010, 3'd4, 0, 1'b0, 32'hA5B6_C7D8, 2, "R8 full word with stall");
    run_req(8'd2, 5'd0, 3'd1, 12'h00E, 3'd2, 2, 1'b0, 32'h1122_3344, 0, "R4 marker retry R7 half");
    run_req(8'd3, 5'd7, 3'd0, 12'h007, 3'd1, 1, 1'b1, 32'hDEAD_BEEF, 0, "R4 status retry R7 byte");
    run_req(8'd4, 5'd1, 3'd2, 12'h100, 3'd4, LIMIT, 1'b0, 32'h0BAD_F00D, 0, "R5 last reissue succeeds");
    run_req(8'd5, 5'd3, 3'd0, 12'h004, 3'd4, LIMIT + 1, 1'b0, 32'h0, 0, "R5 timeout all ones");
    run_req(8'd5, 5'd3, 3'd0, 12'h006, 3'd2, LIMIT + 1, 1'b1, 32'h0, 0, "R5 timeout half R7");
    run_req(8'd0, 5'd0, 3'd0, 12'h000, 3'd4, 1, 1'b0, 32'h0, 0, "R6 direct marker kept");
    run_req(8'd0, 5'd0, 3'd1, 12'h008, 3'd4, 1, 1'b1, 32'h0, 0, "R6 direct status ignored");
    run_req(8'd0, 5'd1, 3'd0, 12'h000, 3'd4, 0, 1'b0, 32'h0, 0, "R2 bus0 device1");
    run_req(8'd20, 5'd0, 3'd0, 12'h000, 3'd4, 0, 1'b0, 32'h0, 0, "R2 bus above last");
    run_req(8'd6, 5'd4, 3'd5, 12'h021, 3'd1, 0, 1'b0, 32'h1234_5678, 0, "R7 byte lane 1");
    run_req(8'd7, 5'd5, 3'd6, 12'h02C, 3'd3, 0, 1'b0, 32'h89AB_CDEF, 0, "R8 odd size full word");
    summary();
  end
endmodule